// File: doc/BRIEF.md
# PHY Receive Error Counters and Test Control Registers

This block holds three management registers of a 100BASE-TX physical layer: two 16-bit receive event counters and one test and control word. For each frame the receiver reports a start strobe together with the first two 5-bit code groups it saw. A frame counts as a false carrier when those code groups are not the start-of-stream delimiter pair. Every such frame advances the false-carrier counter. It also advances the disconnect counter, but only while the repeater-mode input is high. Both counters stop at full scale and return to zero when they are read.

The control word turns management writes into two kinds of output. Two command bits each produce a one-cycle pulse, one for a clock-synthesizer shift and one for a load. The pulses are handled by a small state machine whose states are `CMD_IDLE`, `CMD_SHIFT` and `CMD_LOAD`. A control write with only the shift bit set takes the transition `CMD_IDLE->CMD_SHIFT`. A control write with only the load bit set takes `CMD_IDLE->CMD_LOAD`. Any pulse state goes back to `CMD_IDLE` after one cycle, unless another single-command write arrives in that cycle and takes it to `CMD_SHIFT` or `CMD_LOAD`. A write with both command bits set, or with neither, leads to `CMD_IDLE`. Three other bits are level enables for the test modes. The read port is registered: `reg_rdata` takes its value at the clock edge that samples `reg_rd` and holds it until the next read.

Top module: `phy_mgmt_regs`

## Requirements
- R1: At each clock edge where `frm_start` is high, the false-carrier counter (address 19) goes up by one unless `frm_cg0` is 5'b11000 and `frm_cg1` is 5'b10001. A frame that carries this pair does not change the counter.
- R2: The disconnect counter (address 20) goes up for a frame with a bad start only when `rpt_mode` is high in the same cycle. Otherwise it keeps its value.
- R3: When a counter holds 16'hFFFF, further bad-start frames leave it at 16'hFFFF.
- R4: Both counters are 0 after reset. A read with `reg_rd` high returns the counter value on `reg_rdata` after that clock edge and sets the counter to 0.
- R5: When a counted event and a read of the same counter fall in the same cycle, the read returns the old value and the counter becomes 1.
- R6: A control write (address 18) with bit 15 set and bit 14 clear raises `synth_shift_pulse` for exactly the next cycle. In that cycle bit 15 of the control word reads as 1, and it reads as 0 afterwards.
- R7: A control write with bit 14 set and bit 15 clear raises `synth_load_pulse` for exactly the next cycle. In that cycle bit 14 reads as 1, and it reads as 0 afterwards.
- R8: A control write with bits 15 and 14 both set issues no pulse, and both bits read as 0.
- R9: Control bits 13, 12 and 11 are written and read back, and drive `brkdn_tmr_en`, `eq_probe_en` and `tenb_probe_en`. All three are 0 after reset.
- R10: Control bits 10:5 read as 0 and bits 4:0 read as the PHY address 5'b00001, whatever is written to them. Writes to addresses 19 and 20 change nothing.
- R11: A read of any address other than 18, 19 or 20 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Frame start strobe, one cycle per frame |
| frm_cg0 | input | 5 | First received code group of the frame |
| frm_cg1 | input | 5 | Second received code group of the frame |
| rpt_mode | input | 1 | Repeater mode is active |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe; clears a counter that is read |
| reg_rdata | output | 16 | Registered read data |
| synth_shift_pulse | output | 1 | One-cycle clock-synthesizer shift command |
| synth_load_pulse | output | 1 | One-cycle clock-synthesizer load command |
| brkdn_tmr_en | output | 1 | Break-down timer enable |
| eq_probe_en | output | 1 | Equalizer probe mode enable |
| tenb_probe_en | output | 1 | 10BASE-T probe mode enable |

## Verification
The bench builds the block with its default parameters: 16-bit counters and PHY address 5'b00001. With these values, about 65 thousand back-to-back bad-start frames drive both counters to their ceiling, so saturation is tested at the real register width and not at a reduced one. The same defaults make the exact control-word read value predictable, with the PHY address in the low field, in every command and enable case.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int unsigned REG_AW = 5;
    localparam int unsigned REG_DW = 16;
    localparam int unsigned CG_W   = 5;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 5'd18;
    localparam logic [REG_AW-1:0] ADDR_FCC  = 5'd19;
    localparam logic [REG_AW-1:0] ADDR_DISC = 5'd20;

    localparam int unsigned BIT_SHIFT = 15;
    localparam int unsigned BIT_LOAD  = 14;
    localparam int unsigned BIT_BDT   = 13;
    localparam int unsigned BIT_EQP   = 12;
    localparam int unsigned BIT_TENP  = 11;
    localparam int unsigned PHYAD_W   = 5;

    localparam logic [CG_W-1:0] SSD_FIRST  = 5'b11000;
    localparam logic [CG_W-1:0] SSD_SECOND = 5'b10001;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_SHIFT = 2'd1,
        CMD_LOAD  = 2'd2
    } cmd_state_t;

endpackage

// File: rtl/ssd_start_check.sv
module ssd_start_check
    import phy_mgmt_pkg::*;
(
    input  logic            start,
    input  logic [CG_W-1:0] cg0,
    input  logic [CG_W-1:0] cg1,
    output logic            bad_start
);
    always_comb begin
        bad_start = start && ((cg0 != SSD_FIRST) || (cg1 != SSD_SECOND));
    end
endmodule

// File: rtl/sat_rc_counter.sv
module sat_rc_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_ONE : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/synth_cmd_ctrl.sv
module synth_cmd_ctrl
    import phy_mgmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sel,
    input  logic [1:0] wr_cmd,
    input  logic [2:0] wr_lvl,
    output logic       shift_p,
    output logic       load_p,
    output logic [2:0] lvl_en
);
    cmd_state_t state_q;
    cmd_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = CMD_IDLE;
        if (wr_sel) begin
            unique case (wr_cmd)
                2'b10:   state_d = CMD_SHIFT;
                2'b01:   state_d = CMD_LOAD;
                default: state_d = CMD_IDLE;
            endcase
        end
    end

    always_comb begin
        shift_p = 1'b0;
        load_p  = 1'b0;
        unique case (state_q)
            CMD_IDLE:  ;
            CMD_SHIFT: shift_p = 1'b1;
            CMD_LOAD:  load_p  = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_en <= '0;
        end else if (wr_sel) begin
            lvl_en <= wr_lvl;
        end
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned        CNT_W   = 16,
    parameter logic [PHYAD_W-1:0] PHY_ADR = 5'b00001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic [CG_W-1:0]   frm_cg0,
    input  logic [CG_W-1:0]   frm_cg1,
    input  logic              rpt_mode,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              synth_shift_pulse,
    output logic              synth_load_pulse,
    output logic              brkdn_tmr_en,
    output logic              eq_probe_en,
    output logic              tenb_probe_en
);
    localparam int unsigned PAD_W = REG_DW - CNT_W;

    logic             bad_start;
    logic             fc_clr;
    logic             dc_clr;
    logic [CNT_W-1:0] fc_cnt;
    logic [CNT_W-1:0] dc_cnt;
    logic             ctrl_wr;
    logic [2:0]       lvl_en;
    logic [REG_DW-1:0] ctrl_word;
    logic             unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata[BIT_TENP-1:0];

    ssd_start_check u_ssd (
        .start     (frm_start),
        .cg0       (frm_cg0),
        .cg1       (frm_cg1),
        .bad_start (bad_start)
    );

    assign fc_clr = reg_rd && (reg_addr == ADDR_FCC);
    assign dc_clr = reg_rd && (reg_addr == ADDR_DISC);

    sat_rc_counter #(.W(CNT_W)) u_fc_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (bad_start),
        .clr   (fc_clr),
        .cnt   (fc_cnt)
    );

    sat_rc_counter #(.W(CNT_W)) u_dc_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (bad_start && rpt_mode),
        .clr   (dc_clr),
        .cnt   (dc_cnt)
    );

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    synth_cmd_ctrl u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (ctrl_wr),
        .wr_cmd  (reg_wdata[BIT_SHIFT:BIT_LOAD]),
        .wr_lvl  (reg_wdata[BIT_BDT:BIT_TENP]),
        .shift_p (synth_shift_pulse),
        .load_p  (synth_load_pulse),
        .lvl_en  (lvl_en)
    );

    assign brkdn_tmr_en  = lvl_en[2];
    assign eq_probe_en   = lvl_en[1];
    assign tenb_probe_en = lvl_en[0];

    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[BIT_SHIFT]        = synth_shift_pulse;
        ctrl_word[BIT_LOAD]         = synth_load_pulse;
        ctrl_word[BIT_BDT:BIT_TENP] = lvl_en;
        ctrl_word[PHYAD_W-1:0]      = PHY_ADR;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    reg_rdata <= '0;
                end else if (reg_rd) begin
                    unique case (reg_addr)
                        ADDR_CTRL: reg_rdata <= ctrl_word;
                        ADDR_FCC:  reg_rdata <= {{PAD_W{1'b0}}, fc_cnt};
                        ADDR_DISC: reg_rdata <= {{PAD_W{1'b0}}, dc_cnt};
                        default:   reg_rdata <= '0;
                    endcase
                end
            end
        end else begin : g_full
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    reg_rdata <= '0;
                end else if (reg_rd) begin
                    unique case (reg_addr)
                        ADDR_CTRL: reg_rdata <= ctrl_word;
                        ADDR_FCC:  reg_rdata <= fc_cnt[REG_DW-1:0];
                        ADDR_DISC: reg_rdata <= dc_cnt[REG_DW-1:0];
                        default:   reg_rdata <= '0;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              rpt_mode,
    input logic              bad_start,
    input logic              fc_clr,
    input logic              dc_clr,
    input logic [CNT_W-1:0]  fc_cnt,
    input logic [CNT_W-1:0]  dc_cnt,
    input logic              synth_shift_pulse,
    input logic              synth_load_pulse
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    p_fc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fc_clr) |-> ((fc_cnt == $past(fc_cnt)) || (fc_cnt == $past(fc_cnt) + ONE)))
        else $error("p_fc_step_r1");

    p_dc_repeater_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rpt_mode) && !$past(dc_clr)) |-> (dc_cnt == $past(dc_cnt)))
        else $error("p_dc_repeater_only_r2");

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fc_cnt) == FULL) && !$past(fc_clr)) |-> (fc_cnt == FULL))
        else $error("p_no_wrap_r3");

    p_clear_keeps_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fc_clr) |-> (fc_cnt == ($past(bad_start) ? ONE : '0)))
        else $error("p_clear_keeps_event_r5");

    p_shift_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        synth_shift_pulse |-> $past(reg_wr && (reg_addr == ADDR_CTRL)
                                    && reg_wdata[BIT_SHIFT] && !reg_wdata[BIT_LOAD]))
        else $error("p_shift_cause_r6");

    p_load_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        synth_load_pulse |-> $past(reg_wr && (reg_addr == ADDR_CTRL)
                                   && reg_wdata[BIT_LOAD] && !reg_wdata[BIT_SHIFT]))
        else $error("p_load_cause_r7");

    p_cmd_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(synth_shift_pulse && synth_load_pulse))
        else $error("p_cmd_exclusive_r8");
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .reg_wr            (reg_wr),
    .reg_addr          (reg_addr),
    .reg_wdata         (reg_wdata),
    .rpt_mode          (rpt_mode),
    .bad_start         (bad_start),
    .fc_clr            (fc_clr),
    .dc_clr            (dc_clr),
    .fc_cnt            (fc_cnt),
    .dc_cnt            (dc_cnt),
    .synth_shift_pulse (synth_shift_pulse),
    .synth_load_pulse  (synth_load_pulse)
);

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_start = 1'b0;
    logic [4:0]  frm_cg0 = 5'b0;
    logic [4:0]  frm_cg1 = 5'b0;
    logic        rpt_mode = 1'b0;
    logic [4:0]  reg_addr = 5'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic        synth_shift_pulse;
    logic        synth_load_pulse;
    logic        brkdn_tmr_en;
    logic        eq_probe_en;
    logic        tenb_probe_en;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic rd_seen = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    phy_mgmt_regs u_dut (
        .clk (clk), .rst_n (rst_n),
        .frm_start (frm_start), .frm_cg0 (frm_cg0), .frm_cg1 (frm_cg1),
        .rpt_mode (rpt_mode), .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rd (reg_rd), .reg_rdata (reg_rdata),
        .synth_shift_pulse (synth_shift_pulse), .synth_load_pulse (synth_load_pulse),
        .brkdn_tmr_en (brkdn_tmr_en), .eq_probe_en (eq_probe_en),
        .tenb_probe_en (tenb_probe_en)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each registered read result with the queued expectation
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", reg_rdata, 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(reg_rdata == e, t, reg_rdata, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            check(1'b0, "watchdog", 16'h0, 16'h0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // driver tasks: all drive at the falling edge
    task automatic idle();
        @(negedge clk);
        frm_start = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        frm_start = 1'b0; reg_wr = 1'b0;
        reg_addr = a; reg_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        idle();
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b0; frm_start = 1'b0;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        idle();
    endtask

    task automatic frame(input logic [4:0] c0, input logic [4:0] c1);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        frm_cg0 = c0; frm_cg1 = c1; frm_start = 1'b1;
        idle();
    endtask

    task automatic cmd_pulse(input logic [15:0] d, input bit exp_s, input bit exp_l, input string t);
        @(negedge clk);
        reg_addr = 5'd18; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0;
        check(synth_shift_pulse == exp_s, {t, " shift pulse"}, 16'(synth_shift_pulse), 16'(exp_s));
        check(synth_load_pulse == exp_l, {t, " load pulse"}, 16'(synth_load_pulse), 16'(exp_l));
        reg_rd = 1'b1;
        exp_q.push_back({exp_s, exp_l, 9'b0, 5'b00001}); tag_q.push_back({t, " ctrl during pulse"});
        @(negedge clk);
        reg_rd = 1'b0;
        check(!synth_shift_pulse && !synth_load_pulse, {t, " pulse one cycle"},
              16'({synth_shift_pulse, synth_load_pulse}), 16'h0);
        rd(5'd18, 16'h0001, {t, " ctrl after pulse"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(reg_rdata == 16'h0 && !synth_shift_pulse && !synth_load_pulse, "R4 reset outputs",
              reg_rdata, 16'h0);
        check({brkdn_tmr_en, eq_probe_en, tenb_probe_en} == 3'b000, "R9 reset enables",
              16'({brkdn_tmr_en, eq_probe_en, tenb_probe_en}), 16'h0);
        rst_n = 1'b1;
        idle();
        rd(5'd18, 16'h0001, "R10 ctrl reset value");
        rd(5'd19, 16'h0000, "R4 false carrier reset");
        rd(5'd20, 16'h0000, "R4 disconnect reset");

        // R1: good delimiter not counted
        repeat (3) frame(5'b11000, 5'b10001);
        rd(5'd19, 16'h0000, "R1 good starts not counted");

        // R1: assorted bad starts, repeater off
        frame(5'b11001, 5'b10001);
        frame(5'b11000, 5'b10000);
        frame(5'b10001, 5'b11000);
        frame(5'b00000, 5'b00000);
        frame(5'b11111, 5'b10001);
        rd(5'd19, 16'd5, "R1 bad starts counted");
        rd(5'd19, 16'd0, "R4 cleared by read");
        rd(5'd20, 16'd0, "R2 no count outside repeater mode");

        // R2: repeater mode
        @(negedge clk); rpt_mode = 1'b1;
        repeat (4) frame(5'b01010, 5'b10001);
        repeat (2) frame(5'b11000, 5'b10001);
        @(negedge clk); rpt_mode = 1'b0;
        rd(5'd20, 16'd4, "R2 repeater bad starts");
        rd(5'd19, 16'd4, "R1 counted in repeater mode too");

        // R5: event and read in the same cycle
        frame(5'b00001, 5'b00001);
        frame(5'b00001, 5'b00001);
        @(negedge clk);
        frm_cg0 = 5'b00111; frm_cg1 = 5'b00111; frm_start = 1'b1;
        reg_addr = 5'd19; reg_rd = 1'b1;
        exp_q.push_back(16'd2); tag_q.push_back("R5 read returns old value");
        idle();
        rd(5'd19, 16'd1, "R5 colliding event kept");

        // R6, R7, R8: command pulses
        cmd_pulse(16'h8000, 1'b1, 1'b0, "R6");
        cmd_pulse(16'h4000, 1'b0, 1'b1, "R7");
        cmd_pulse(16'hC000, 1'b0, 1'b0, "R8");

        // R9, R10: level enables and fixed fields
        wr(5'd18, 16'h3FFF);
        check({brkdn_tmr_en, eq_probe_en, tenb_probe_en} == 3'b111, "R9 enables set",
              16'({brkdn_tmr_en, eq_probe_en, tenb_probe_en}), 16'h7);
        rd(5'd18, 16'h3801, "R10 reserved and address fields fixed");
        wr(5'd18, 16'h1000);
        check({brkdn_tmr_en, eq_probe_en, tenb_probe_en} == 3'b010, "R9 equalizer only",
              16'({brkdn_tmr_en, eq_probe_en, tenb_probe_en}), 16'h2);
        rd(5'd18, 16'h1001, "R9 readback");
        wr(5'd19, 16'hFFFF);
        wr(5'd20, 16'h1234);
        rd(5'd19, 16'h0000, "R10 counter write ignored");
        rd(5'd20, 16'h0000, "R10 counter write ignored");

        // R11: unmapped address
        rd(5'd7, 16'h0000, "R11 unmapped address");
        rd(5'd21, 16'h0000, "R11 unmapped address");

        // R3: saturation
        @(negedge clk);
        rpt_mode = 1'b1; frm_cg0 = 5'b0; frm_cg1 = 5'b0; frm_start = 1'b1;
        repeat (65540) @(negedge clk);
        frm_start = 1'b0; rpt_mode = 1'b0;
        rd(5'd19, 16'hFFFF, "R3 false carrier saturates");
        rd(5'd20, 16'hFFFF, "R3 disconnect saturates");
        rd(5'd19, 16'h0000, "R4 clear after saturation");

        repeat (3) idle();
        check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule